// File: doc/BRIEF.md
# Interrupt Source Configuration and Routing Unit

This unit holds a configuration word pair for each of a fixed set of interrupt sources and turns activity on the source lines into delivery requests for one or more interrupt targets. The first word of each pair sets the priority, the vector, the mask, the delivery mode and, for externally wired sources, the input polarity and sense. The second word holds the destination bitmap with one bit per target. The unit keeps an activity bit for each source. The bit is set when a request goes out. A level source clears it by deasserting. An edge source clears it through a completion strobe from the downstream presentation logic.

Each request leaves as a single-cycle pulse. The pulse carries the source index and a target bitmap. In directed mode the bitmap copies every destination bit. In distributed mode it names exactly one target, chosen round-robin among the destination bits. Arbitration between sources competing for a target, acknowledge handling and bus protocol all live outside this unit.

Top module: `irq_route`

## Requirements
- R1: After reset the vector/priority word of every source reads 0xA0000000 (masked, distributed mode). Every destination word reads zero, and no request is issued.
- R2: Vector/priority word layout: bit 31 mask (1 = masked), bit 30 activity, bit 29 mode (1 = distributed), bit 23 polarity, bit 22 sense (1 = level), bits 19:16 priority, bits 7:0 vector. A write always updates mask, mode, priority and vector. Writes to the activity bit are ignored. All other bits read zero. Polarity and sense are writable only on external sources (index below NEXT = 6); on any other source they read zero.
- R3: While a source's activity bit is set, writes leave its polarity and sense unchanged.
- R4: The destination word keeps bits 31:30 and bits NTGT-1:0 (NTGT = 4). Every other bit reads zero.
- R5: A source that is masked, has priority zero, or has an all-zero destination word raises no request.
- R6: An edge source asserts on a rising edge of its effective level, which is the line XOR the polarity bit (polarity 1 = active low). An assertion while the activity bit is set is ignored. Deassertion has no effect.
- R7: A level source with an effective level of 1 and a clear activity bit raises a request. When its effective level falls while it is active, its activity bit clears.
- R8: With mode 0, or when the destination word holds only the bit of the last target used, the request bitmap equals the destination bitmap.
- R9: With mode 1, the request names one target: the next set destination bit after the last target used, wrapping around. That target becomes the last target used. The last target used resets to 0.
- R10: The request pulse appears one cycle after the clock edge that sees the event and lasts one cycle. The activity bit reads 1 from the same cycle.
- R11: When several sources assert together, requests leave in ascending source order, one per cycle. An edge event that waits for its turn is held and is not lost.
- R12: A completion strobe naming an edge source clears that source's activity bit. The strobe has no effect on level sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLine | input | NSRC | Raw interrupt source lines |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 = vector/priority word, 1 = destination word |
| regIdx | input | IDX_W | Source index for register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regIdx/regSel (combinational) |
| ackValid | input | 1 | Completion strobe from the presentation logic |
| ackSrc | input | IDX_W | Source index of the completion |
| reqValid | output | 1 | Request pulse |
| reqSrc | output | IDX_W | Source index of the request |
| reqTgt | output | NTGT | Target bitmap of the request |

## Verification
The bench aims at three weak points. The first is the activity lock. A design that lets polarity or sense change while a request is pending reads back the new bits early. The second is repeat suppression. A design that fails to ignore a second edge, or a held level, while active sends duplicate pulses. A level source that never clears its activity bit on deassertion stays silent on its next assertion. The third is the round-robin wrap. A faulty pointer repeats a target, skips one, or fails to wrap from the top bit to the bottom. The bench also drives two edge sources in one cycle. A design without held edge events loses the higher-numbered request, and a design with the wrong priority order sends them in the wrong sequence.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int NSRC   = 8;
  localparam int NTGT   = 4;
  localparam int NEXT   = 6;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int TIDX_W = $clog2(NTGT);

  localparam int B_MASK = 31;
  localparam int B_ACT  = 30;
  localparam int B_MODE = 29;
  localparam int B_POL  = 23;
  localparam int B_SENS = 22;
  localparam int B_PRIO = 16;

  typedef struct packed {
    logic              issue;
    logic [IDX_W-1:0]  src;
    logic [NTGT-1:0]   tgt;
    logic              updLast;
    logic [TIDX_W-1:0] newLast;
    logic [NSRC-1:0]   keepEdge;
    logic [NSRC-1:0]   clrAct;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NSRC-1:0]              srcLine,
  input  logic                         regWrEn,
  input  logic                         regSel,
  input  logic [IDX_W-1:0]             regIdx,
  input  logic [31:0]                  regWrData,
  output logic [31:0]                  regRdData,
  input  ctlStrobe_t                   strb,
  output logic [NSRC-1:0]              maskV,
  output logic [NSRC-1:0]              modeV,
  output logic [NSRC-1:0]              senseV,
  output logic [NSRC-1:0][PRIO_W-1:0]  prioV,
  output logic [NSRC-1:0][NTGT-1:0]    destV,
  output logic [NSRC-1:0]              activeV,
  output logic [NSRC-1:0]              edgePendV,
  output logic [NSRC-1:0][TIDX_W-1:0]  lastV,
  output logic [NSRC-1:0]              lvlV,
  output logic [NSRC-1:0]              riseV,
  output logic                         reqValid,
  output logic [IDX_W-1:0]             reqSrc,
  output logic [NTGT-1:0]              reqTgt
);
  logic [NSRC-1:0]             polV;
  logic [NSRC-1:0][VEC_W-1:0]  vecV;
  logic [NSRC-1:0][1:0]        destHiV;
  logic [NSRC-1:0]             prevLvl;

  assign lvlV  = srcLine ^ polV;
  assign riseV = lvlV & ~prevLvl;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic hitWr;
    assign hitWr = regWrEn && (regIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskV[i]   <= 1'b1;
        modeV[i]   <= 1'b1;
        polV[i]    <= 1'b0;
        senseV[i]  <= 1'b0;
        prioV[i]   <= '0;
        vecV[i]    <= '0;
        destV[i]   <= '0;
        destHiV[i] <= '0;
        activeV[i] <= 1'b0;
        lastV[i]   <= '0;
      end else begin
        if (hitWr && !regSel) begin
          maskV[i] <= regWrData[B_MASK];
          modeV[i] <= regWrData[B_MODE];
          prioV[i] <= regWrData[B_PRIO +: PRIO_W];
          vecV[i]  <= regWrData[VEC_W-1:0];
          if (i < NEXT && !activeV[i]) begin
            polV[i]   <= regWrData[B_POL];
            senseV[i] <= regWrData[B_SENS];
          end
        end
        if (hitWr && regSel) begin
          destHiV[i] <= regWrData[31:30];
          destV[i]   <= regWrData[NTGT-1:0];
        end
        if (strb.issue && strb.src == IDX_W'(i)) activeV[i] <= 1'b1;
        else if (strb.clrAct[i])                  activeV[i] <= 1'b0;
        if (strb.updLast && strb.src == IDX_W'(i)) lastV[i] <= strb.newLast;
      end
    end

    // R3
    lock_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(activeV[i]) |-> ($stable(polV[i]) && $stable(senseV[i])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLvl   <= '0;
      edgePendV <= '0;
      reqValid  <= 1'b0;
      reqSrc    <= '0;
      reqTgt    <= '0;
    end else begin
      prevLvl   <= lvlV;
      edgePendV <= strb.keepEdge;
      reqValid  <= strb.issue;
      reqSrc    <= strb.src;
      reqTgt    <= strb.tgt;
    end
  end

  always_comb begin
    regRdData = '0;
    if (!regSel) begin
      regRdData[B_MASK]            = maskV[regIdx];
      regRdData[B_ACT]             = activeV[regIdx];
      regRdData[B_MODE]            = modeV[regIdx];
      regRdData[B_POL]             = polV[regIdx];
      regRdData[B_SENS]            = senseV[regIdx];
      regRdData[B_PRIO +: PRIO_W]  = prioV[regIdx];
      regRdData[VEC_W-1:0]         = vecV[regIdx];
    end else begin
      regRdData[31:30]             = destHiV[regIdx];
      regRdData[NTGT-1:0]          = destV[regIdx];
    end
  end

  // R10
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && $past(reqValid)) |-> (reqSrc != $past(reqSrc)));
endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
  import irq_route_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NSRC-1:0]              maskV,
  input  logic [NSRC-1:0]              modeV,
  input  logic [NSRC-1:0]              senseV,
  input  logic [NSRC-1:0][PRIO_W-1:0]  prioV,
  input  logic [NSRC-1:0][NTGT-1:0]    destV,
  input  logic [NSRC-1:0]              activeV,
  input  logic [NSRC-1:0]              edgePendV,
  input  logic [NSRC-1:0][TIDX_W-1:0]  lastV,
  input  logic [NSRC-1:0]              lvlV,
  input  logic [NSRC-1:0]              riseV,
  input  logic                         ackValid,
  input  logic [IDX_W-1:0]             ackSrc,
  output ctlStrobe_t                   strb
);
  logic [NSRC-1:0]   allowed, assertEv, elig;
  logic              found, rrSel, rrFound;
  logic [IDX_W-1:0]  pick;
  logic [NTGT-1:0]   destP;
  logic [TIDX_W-1:0] lastP, rrIdx;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      allowed[i]  = !maskV[i] && (prioV[i] != '0) && (destV[i] != '0);
      assertEv[i] = senseV[i] ? lvlV[i] : (edgePendV[i] | riseV[i]);
      elig[i]     = allowed[i] && assertEv[i] && !activeV[i];
    end
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && !found) begin
        found = 1'b1;
        pick  = IDX_W'(i);
      end
    end
    destP   = destV[pick];
    lastP   = lastV[pick];
    rrSel   = modeV[pick] && (destP != (NTGT'(1) << lastP));
    rrFound = 1'b0;
    rrIdx   = lastP;
    for (int k = 1; k <= NTGT; k++) begin
      if (!rrFound && destP[(int'(lastP) + k) % NTGT]) begin
        rrFound = 1'b1;
        rrIdx   = TIDX_W'((int'(lastP) + k) % NTGT);
      end
    end

    strb.issue   = found;
    strb.src     = pick;
    strb.updLast = found && rrSel;
    strb.newLast = rrIdx;
    strb.tgt     = !found ? '0 : (rrSel ? (NTGT'(1) << rrIdx) : destP);
    for (int i = 0; i < NSRC; i++) begin
      strb.keepEdge[i] = !senseV[i] && elig[i] && !(found && pick == IDX_W'(i));
      strb.clrAct[i]   = (allowed[i] && senseV[i] && activeV[i] && !lvlV[i]) ||
                         (ackValid && ackSrc == IDX_W'(i) && !senseV[i]);
    end
  end

  // R8
  tgt_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (strb.tgt != '0));

  // R9
  rr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && rrSel) |-> $onehot(strb.tgt));
endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcLine,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackSrc,
  output logic              reqValid,
  output logic [IDX_W-1:0]  reqSrc,
  output logic [NTGT-1:0]   reqTgt
);
  ctlStrobe_t                  strb;
  logic [NSRC-1:0]             maskV, modeV, senseV, activeV, edgePendV, lvlV, riseV;
  logic [NSRC-1:0][PRIO_W-1:0] prioV;
  logic [NSRC-1:0][NTGT-1:0]   destV;
  logic [NSRC-1:0][TIDX_W-1:0] lastV;

  irq_route_regs u_regs (
    .clk(clk), .rstN(rstN), .srcLine(srcLine), .regWrEn(regWrEn),
    .regSel(regSel), .regIdx(regIdx), .regWrData(regWrData),
    .regRdData(regRdData), .strb(strb), .maskV(maskV), .modeV(modeV),
    .senseV(senseV), .prioV(prioV), .destV(destV), .activeV(activeV),
    .edgePendV(edgePendV), .lastV(lastV), .lvlV(lvlV), .riseV(riseV),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqTgt(reqTgt)
  );

  irq_route_ctl u_ctl (
    .clk(clk), .rstN(rstN), .maskV(maskV), .modeV(modeV), .senseV(senseV),
    .prioV(prioV), .destV(destV), .activeV(activeV), .edgePendV(edgePendV),
    .lastV(lastV), .lvlV(lvlV), .riseV(riseV), .ackValid(ackValid),
    .ackSrc(ackSrc), .strb(strb)
  );
endmodule

// File: tb/tb_irq_route.sv
module tb_irq_route;
  import irq_route_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NSRC-1:0]   srcLine = '0;
  logic              regWrEn = 1'b0;
  logic              regSel = 1'b0;
  logic [IDX_W-1:0]  regIdx = '0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic              ackValid = 1'b0;
  logic [IDX_W-1:0]  ackSrc = '0;
  logic              reqValid;
  logic [IDX_W-1:0]  reqSrc;
  logic [NTGT-1:0]   reqTgt;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  irq_route dut (
    .clk(clk), .rstN(rstN), .srcLine(srcLine), .regWrEn(regWrEn),
    .regSel(regSel), .regIdx(regIdx), .regWrData(regWrData),
    .regRdData(regRdData), .ackValid(ackValid), .ackSrc(ackSrc),
    .reqValid(reqValid), .reqSrc(reqSrc), .reqTgt(reqTgt)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic sel, int idx, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regIdx = IDX_W'(idx); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic sel, int idx, output logic [31:0] d);
    regSel = sel; regIdx = IDX_W'(idx);
    #1 d = regRdData;
  endtask

  task automatic ack(int idx);
    @(negedge clk);
    ackValid = 1'b1; ackSrc = IDX_W'(idx);
    @(negedge clk);
    ackValid = 1'b0;
  endtask

  task automatic setLine(int idx, logic v);
    @(negedge clk);
    srcLine[idx] = v;
  endtask

  task automatic expReq(string tag, int src, logic [NTGT-1:0] tgt);
    @(negedge clk);
    chk({tag, " valid"}, 32'(reqValid), 32'd1);
    chk({tag, " src"}, 32'(reqSrc), 32'(src));
    chk({tag, " tgt"}, 32'(reqTgt), 32'(tgt));
  endtask

  task automatic expNone(string tag, int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      chk({tag, " no request"}, 32'(reqValid), 32'd0);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int i = 0; i < NSRC; i++) begin
      rd(1'b0, i, d); chk("R1 vp reset", d, 32'hA000_0000);
      rd(1'b1, i, d); chk("R1 dest reset", d, 32'h0);
    end
    chk("R1 no request at reset", 32'(reqValid), 32'd0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(1'b0, 5, 32'hFFFF_FFFF); rd(1'b0, 5, d);
    chk("R2 external source all-ones write", d, 32'hA0CF_00FF);
    wr(1'b0, 5, 32'h8000_0000); rd(1'b0, 5, d);
    chk("R2 external source rewrite", d, 32'h8000_0000);
    wr(1'b0, 7, 32'hFFFF_FFFF); rd(1'b0, 7, d);
    chk("R2 internal source no pol/sense", d, 32'hA00F_00FF);
    wr(1'b0, 7, 32'h8000_0000);
    wr(1'b1, 7, 32'hFFFF_FFFF); rd(1'b1, 7, d);
    chk("R4 dest kept bits", d, 32'hC000_000F);
    wr(1'b1, 7, 32'h0);
  endtask

  task automatic t_ignore();
    wr(1'b1, 6, 32'h1);
    wr(1'b0, 6, 32'h8003_0006);
    setLine(6, 1'b1); expNone("R5 masked", 2);
    wr(1'b0, 6, 32'h0000_0006);
    setLine(6, 1'b0); setLine(6, 1'b1); expNone("R5 priority zero", 2);
    wr(1'b0, 6, 32'h0003_0006); wr(1'b1, 6, 32'h0);
    setLine(6, 1'b0); setLine(6, 1'b1); expNone("R5 dest zero", 2);
    wr(1'b1, 6, 32'h1);
    setLine(6, 1'b0); setLine(6, 1'b1); expReq("R5 enabled path", 6, 4'h1);
    ack(6); setLine(6, 1'b0);
    wr(1'b0, 6, 32'h8000_0000);
  endtask

  task automatic t_edge_multicast();
    logic [31:0] d;
    wr(1'b1, 0, 32'h5);
    wr(1'b0, 0, 32'h0003_0042);
    setLine(0, 1'b1);
    expReq("R8 multicast", 0, 4'h5);
    rd(1'b0, 0, d); chk("R10 activity set", d, 32'h4003_0042);
    expNone("R10 single pulse", 1);
    setLine(0, 1'b0); expNone("R6 deassert", 1);
    rd(1'b0, 0, d); chk("R6 deassert keeps activity", d, 32'h4003_0042);
    setLine(0, 1'b1); expNone("R6 edge while active", 2);
    wr(1'b0, 0, 32'h00C3_0042); rd(1'b0, 0, d);
    chk("R3 pol/sense locked", d, 32'h4003_0042);
    ack(0); rd(1'b0, 0, d);
    chk("R12 ack clears edge activity", d, 32'h0003_0042);
    setLine(0, 1'b0);
    wr(1'b0, 0, 32'h0043_0042); rd(1'b0, 0, d);
    chk("R3 sense writable when idle", d, 32'h0043_0042);
    wr(1'b0, 0, 32'h8000_0000);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(1'b1, 1, 32'h2);
    wr(1'b0, 1, 32'h0042_0011);
    setLine(1, 1'b1); expReq("R7 level assert", 1, 4'h2);
    expNone("R7 held level", 2);
    ack(1); rd(1'b0, 1, d);
    chk("R12 ack ignored for level", d, 32'h4042_0011);
    setLine(1, 1'b0);
    @(negedge clk); rd(1'b0, 1, d);
    chk("R7 deassert clears activity", d, 32'h0042_0011);
    setLine(1, 1'b1); expReq("R7 level reassert", 1, 4'h2);
    setLine(1, 1'b0);
    @(negedge clk);
    wr(1'b0, 1, 32'h8000_0000);
  endtask

  task automatic t_polarity();
    setLine(2, 1'b1);
    wr(1'b1, 2, 32'h8);
    wr(1'b0, 2, 32'h0081_0003);
    expNone("R6 inverted idle", 2);
    setLine(2, 1'b0); expReq("R6 active-low edge", 2, 4'h8);
    ack(2);
    wr(1'b0, 2, 32'h8000_0000);
  endtask

  task automatic t_roundrobin();
    logic [NTGT-1:0] seq [4] = '{4'h2, 4'h8, 4'h1, 4'h2};
    wr(1'b1, 3, 32'hB);
    wr(1'b0, 3, 32'h2001_0003);
    for (int n = 0; n < 4; n++) begin
      setLine(3, 1'b1); expReq("R9 round-robin", 3, seq[n]);
      setLine(3, 1'b0); ack(3);
    end
    wr(1'b1, 3, 32'h2);
    setLine(3, 1'b1); expReq("R8 single dest equals last", 3, 4'h2);
    setLine(3, 1'b0); ack(3);
    wr(1'b0, 3, 32'h8000_0000);
  endtask

  task automatic t_order();
    wr(1'b1, 4, 32'h1); wr(1'b1, 5, 32'h2);
    wr(1'b0, 4, 32'h0001_0004); wr(1'b0, 5, 32'h0001_0005);
    @(negedge clk);
    srcLine[5] = 1'b1; srcLine[4] = 1'b1;
    expReq("R11 first lowest", 4, 4'h1);
    expReq("R11 held edge next", 5, 4'h2);
    expNone("R11 nothing after", 1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_ignore();
    t_edge_multicast();
    t_level();
    t_polarity();
    t_roundrobin();
    t_order();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule